// File: doc/BRIEF.md
# Backlight Intensity PWM Controller

This block drives an LCD backlight with a pulse-width modulated signal whose duty follows a 6-bit intensity value and a power enable. The intensity is assembled from two independent sources: its low five bits are written through a small serial register port, and its top bit comes from a discrete control line with inverted sense. A second discrete line switches the backlight on and off.

The serial port belongs to a display timing controller with eight register addresses. Only the duty register changes the backlight. Words sent to the other seven addresses are accepted and then dropped. The PWM stage loads a new duty only at the start of each 64-step period, so a change in intensity never produces a short pulse. A loss of power still cuts the drive at once.

Top module: `bl_backlight_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `level_o` reads 0x20 and `pwm_o` is low.
- R2: A serial word is 8 bits, sent MSB first, one bit per cycle in which both `ser_sel_i` and `ser_valid_i` are high. Cycles with `ser_valid_i` low are skipped. Bits 7:5 hold the register address and bits 4:0 hold the data. The word takes effect at the clock edge that samples its eighth bit. Bits offered while `ser_sel_i` is low are ignored.
- R3: A word to address 2 (duty) replaces `level_o[4:0]` with its data and leaves `level_o[5]` unchanged.
- R4: Words to addresses 0, 1, 3, 4, 5, 6 and 7 leave `level_o` unchanged.
- R5: Dropping `ser_sel_i` before the eighth bit discards the partial word. The next word starts again at bit 7.
- R6: `level_o[5]` equals the inverse of `hi_bit_n_i` as sampled at the previous clock edge.
- R7: With power on and a steady intensity N (0 to 63), every 64 consecutive cycles of `pwm_o` contain exactly N high cycles. N = 0 keeps `pwm_o` low.
- R8: `pwm_o` is low in every cycle that follows a clock edge at which `pwr_en_i` was sampled low. The PWM stage then holds a zero duty until a period boundary after power returns.
- R9: `pwm_o` rises only at the first step of a 64-cycle period, counted from reset release. A steady intensity gives at most one high pulse per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ser_sel_i | input | 1 | Serial frame select; low clears the bit position |
| ser_valid_i | input | 1 | Serial bit strobe |
| ser_bit_i | input | 1 | Serial data bit, MSB first |
| hi_bit_n_i | input | 1 | Intensity bit 5 control, active low |
| pwr_en_i | input | 1 | Backlight power enable |
| pwm_o | output | 1 | PWM backlight drive |
| level_o | output | 6 | Current intensity |

## Verification
The duty register is written with several data values while the top-bit line is held high and low. This shows whether the serial path and the line path each touch only their own bits. Every non-duty address is then written with all-ones data, which exposes any address decode that leaks into the intensity. An aborted frame is sent whose first three bits spell the duty address and whose completion would decode to a duty write. Strobes are also sent while the frame select is low. Together these expose a bit counter that is not cleared or that shifts without select. A seeded random mix of addresses, data, gaps between strobes, line levels and power is then checked by counting high cycles over a full window, with intensities 0 and 63 covered directly. These counts separate an off-by-one compare, a missing power gate and a duty that is loaded mid-period.

// File: rtl/bl_pkg.sv
package bl_pkg;
   localparam int BL_ADDR_W = 3;

   typedef enum logic [BL_ADDR_W-1:0] {
      REG_RESET_CTL = 3'd0,
      REG_PHASE     = 3'd1,
      REG_DUTY      = 3'd2,
      REG_PWR_A     = 3'd3,
      REG_PWR_B     = 3'd4,
      REG_GP_OUT    = 3'd5,
      REG_PIXEL     = 3'd6,
      REG_POLARITY  = 3'd7
   } bl_reg_e;
endpackage

// File: rtl/bl_serial_rx.sv
module bl_serial_rx #(
   parameter int WORD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic              valid_i,
   input  logic              bit_i,
   output logic              done_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   if (WORD_W < 3) begin : g_bad_word
      $error("bl_serial_rx: WORD_W must be at least 3");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-2:0] shift_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         shift_q <= '0;
      end else if (!sel_i) begin
         cnt_q   <= '0;
      end else if (valid_i) begin
         cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         shift_q <= {shift_q[WORD_W-3:0], bit_i};
      end
   end

   assign done_o = sel_i & valid_i & (cnt_q == LAST);
   assign word_o = {shift_q, bit_i};
endmodule

// File: rtl/bl_level_reg.sv
module bl_level_reg
   import bl_pkg::*;
#(
   parameter int INT_W    = 6,
   parameter bit LINE_INV = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             done_i,
   input  logic [BL_ADDR_W+INT_W-2:0] word_i,
   input  logic             line_i,
   input  logic             pwr_line_i,
   output logic [INT_W-1:0] level_o,
   output logic             pwr_o
);
   localparam int DATA_W = INT_W - 1;
   localparam int WORD_W = BL_ADDR_W + DATA_W;

   bl_reg_e           addr;
   logic [DATA_W-1:0] data;
   logic [DATA_W-1:0] low_q;
   logic              top_q;
   logic              top_d;

   assign addr = bl_reg_e'(word_i[WORD_W-1 -: BL_ADDR_W]);
   assign data = word_i[DATA_W-1:0];

   if (LINE_INV) begin : g_line_inv
      assign top_d = ~line_i;
   end else begin : g_line_dir
      assign top_d = line_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         low_q <= '0;
         top_q <= 1'b1;
         pwr_o <= 1'b0;
      end else begin
         top_q <= top_d;
         pwr_o <= pwr_line_i;
         if (done_i && addr == REG_DUTY) begin
            low_q <= data;
         end
      end
   end

   assign level_o = {top_q, low_q};
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm #(
   parameter int INT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pwr_i,
   input  logic [INT_W-1:0] level_i,
   output logic             pwm_o
);
   localparam logic [INT_W-1:0] PH_MAX = '1;

   logic [INT_W-1:0] phase_q;
   logic [INT_W-1:0] duty_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= '0;
         duty_q  <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
         if (!pwr_i) begin
            duty_q <= '0;
         end else if (phase_q == PH_MAX) begin
            duty_q <= level_i;
         end
      end
   end

   assign pwm_o = pwr_i & (phase_q < duty_q);
endmodule

// File: rtl/bl_backlight_ctrl.sv
module bl_backlight_ctrl
   import bl_pkg::*;
#(
   parameter int INT_W    = 6,
   parameter bit LINE_INV = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ser_sel_i,
   input  logic             ser_valid_i,
   input  logic             ser_bit_i,
   input  logic             hi_bit_n_i,
   input  logic             pwr_en_i,
   output logic             pwm_o,
   output logic [INT_W-1:0] level_o
);
   localparam int WORD_W = BL_ADDR_W + INT_W - 1;

   if (INT_W < 2 || INT_W > 12) begin : g_bad_int
      $error("bl_backlight_ctrl: INT_W out of range");
   end

   logic              done;
   logic [WORD_W-1:0] word;
   logic              pwr_q;

   bl_serial_rx #(.WORD_W(WORD_W)) u_rx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (ser_sel_i),
      .valid_i (ser_valid_i),
      .bit_i   (ser_bit_i),
      .done_o  (done),
      .word_o  (word)
   );

   bl_level_reg #(.INT_W(INT_W), .LINE_INV(LINE_INV)) u_level (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .done_i     (done),
      .word_i     (word),
      .line_i     (hi_bit_n_i),
      .pwr_line_i (pwr_en_i),
      .level_o    (level_o),
      .pwr_o      (pwr_q)
   );

   bl_pwm #(.INT_W(INT_W)) u_pwm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pwr_i   (pwr_q),
      .level_i (level_o),
      .pwm_o   (pwm_o)
   );
endmodule

// File: rtl/bl_backlight_ctrl_chk.sv
module bl_backlight_ctrl_chk #(
   parameter int INT_W    = 6,
   parameter bit LINE_INV = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ser_sel_i,
   input logic             ser_valid_i,
   input logic             hi_bit_n_i,
   input logic             pwr_en_i,
   input logic             pwm_o,
   input logic [INT_W-1:0] level_o
);
   logic             armed_q;
   logic [INT_W-1:0] cyc_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         cyc_q   <= '0;
      end else begin
         armed_q <= 1'b1;
         cyc_q   <= cyc_q + 1'b1;
      end
   end

   // R1: reset value visible in the first cycle after release
   p_reset_val_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_q |-> (level_o == INT_W'(1 << (INT_W - 1))) && !pwm_o);

   // R6: top bit follows the line, one edge later
   p_top_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q |-> level_o[INT_W-1] == (LINE_INV ? !$past(hi_bit_n_i) : $past(hi_bit_n_i)));

   // R2: low bits change only on an edge that sampled a selected strobe
   p_low_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && !$stable(level_o[INT_W-2:0])) |-> $past(ser_sel_i && ser_valid_i));

   // R8: power low cuts the drive
   p_pwr_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && !$past(pwr_en_i)) |-> !pwm_o);

   // R9: pulses start only at a period boundary
   p_rise_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_o) |-> cyc_q == '0);
endmodule

bind bl_backlight_ctrl bl_backlight_ctrl_chk #(.INT_W(INT_W), .LINE_INV(LINE_INV)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ser_sel_i   (ser_sel_i),
   .ser_valid_i (ser_valid_i),
   .hi_bit_n_i  (hi_bit_n_i),
   .pwr_en_i    (pwr_en_i),
   .pwm_o       (pwm_o),
   .level_o     (level_o)
);

// File: tb/bl_backlight_ctrl_tb.sv
`timescale 1ns/1ps
module bl_backlight_ctrl_tb;
   localparam int PERIOD = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       valid = 1'b0;
   logic       sbit = 1'b0;
   logic       hi_n = 1'b0;
   logic       pwr = 1'b0;
   logic       pwm;
   logic [5:0] level;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [5:0] exp_level;
   bit         exp_pwr;

   always #2.5 clk = ~clk;

   bl_backlight_ctrl u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ser_sel_i   (sel),
      .ser_valid_i (valid),
      .ser_bit_i   (sbit),
      .hi_bit_n_i  (hi_n),
      .pwr_en_i    (pwr),
      .pwm_o       (pwm),
      .level_o     (level)
   );

   function automatic logic [5:0] model_write(input logic [5:0] cur, input logic [2:0] a,
                                               input logic [4:0] d);
      return (a == 3'd2) ? {cur[5], d} : cur;
   endfunction

   function automatic int model_highs(input logic [5:0] lv, input bit p);
      return p ? int'(lv) : 0;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_word(input logic [2:0] a, input logic [4:0] d, input int gap);
      logic [7:0] w = {a, d};
      for (int i = 7; i >= 0; i--) begin
         for (int g = 0; g < gap; g++) begin
            @(negedge clk); sel = 1'b1; valid = 1'b0;
         end
         @(negedge clk); sel = 1'b1; valid = 1'b1; sbit = w[i];
      end
      @(negedge clk); sel = 1'b0; valid = 1'b0;
      exp_level = model_write(exp_level, a, d);
   endtask

   task automatic set_line(input logic v);
      @(negedge clk); hi_n = v;
      @(negedge clk);
      exp_level[5] = ~v;
   endtask

   task automatic window(output int highs, output int rises);
      logic prev;
      repeat (2 * PERIOD + 2) @(negedge clk);
      highs = 0; rises = 0; prev = pwm;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         if (pwm) highs++;
         if (pwm && !prev) rises++;
         prev = pwm;
      end
   endtask

   task automatic check_pwm(input string req);
      int h, r;
      window(h, r);
      check(req, h, model_highs(exp_level, exp_pwr));
      check({req, "_rise"}, (r <= 1) ? 1 : 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      int h, r;
      seed = $urandom(32'h5EED);
      exp_level = 6'h20; exp_pwr = 1'b0;
      repeat (3) @(negedge clk);
      // R1: during reset
      check("R1 level", level, 6'h20);
      check("R1 pwm", pwm, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 level after release", level, 6'h20);

      // R7: default intensity powered
      pwr = 1'b1; exp_pwr = 1'b1;
      check_pwm("R7 default");

      // R3: duty write keeps bit 5
      send_word(3'd2, 5'h0A, 0);
      check("R3 duty write", level, exp_level);
      check_pwm("R7 level 42");

      // R6: line high clears bit 5
      set_line(1'b1);
      check("R6 line high", level, exp_level);
      check_pwm("R7 level 10");

      // R4: every other address ignored
      for (int a = 0; a < 8; a++) begin
         if (a != 2) begin
            send_word(3'(a), 5'h1F, 0);
            check($sformatf("R4 addr %0d", a), level, exp_level);
         end
      end

      // R7: zero intensity
      send_word(3'd2, 5'h00, 1);
      check("R3 zero write", level, 0);
      check_pwm("R7 zero");

      // R7/R9: full intensity
      set_line(1'b0);
      send_word(3'd2, 5'h1F, 0);
      check("R6 line low", level, 6'h3F);
      check_pwm("R9 full");

      // R8: power drop cuts at once
      @(negedge clk); pwr = 1'b0; exp_pwr = 1'b0;
      @(negedge clk);
      check("R8 immediate off", pwm, 0);
      check_pwm("R8 off window");
      pwr = 1'b1; exp_pwr = 1'b1;

      // R5: aborted frame spelling duty address
      @(negedge clk); sel = 1'b1; valid = 1'b1; sbit = 1'b0;
      @(negedge clk); sbit = 1'b1;
      @(negedge clk); sbit = 1'b0;
      @(negedge clk); sel = 1'b0; valid = 1'b0;
      send_word(3'd3, 5'h0F, 0);
      check("R5 abort discarded", level, exp_level);

      // R2: strobes without select ignored
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); sel = 1'b0; valid = 1'b1; sbit = (i == 1);
      end
      @(negedge clk); valid = 1'b0;
      send_word(3'd2, 5'h15, 0);
      check("R2 select low ignored", level, exp_level);
      check_pwm("R7 level 53");

      // Random mix
      for (int it = 0; it < 25; it++) begin
         logic [2:0] a = 3'($urandom_range(0, 7));
         logic [4:0] d = 5'($urandom_range(0, 31));
         if ($urandom_range(0, 1) == 1) a = 3'd2;
         send_word(a, d, $urandom_range(0, 2));
         check("R2 random word", level, exp_level);
         set_line(1'($urandom_range(0, 1)));
         check("R6 random line", level, exp_level);
         @(negedge clk);
         pwr = ($urandom_range(0, 3) != 0);
         exp_pwr = pwr;
         check_pwm("R7 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule